// File: doc/BRIEF.md
# Load/Store Address Router

This block sits after address translation in a load/store path. It accepts one
physical access at a time (a 32-bit word or a single byte, read or write) and
decides where it goes. A word access with either of its two low address bits
set is refused. Otherwise, an address inside a fixed device window goes to a
device port. Every other address is treated as an offset into RAM, and it is
refused if it lies at or beyond the configured RAM size.

Byte accesses skip the alignment test. When the block is configured
big-endian, a byte access routed to RAM has its two low address bits inverted
before the bound test and before the RAM request is issued. Byte reads come
back zero-extended. Each accepted request gets exactly one response. The
response carries either the read data or a fault code that depends on the
direction of the access. Refused accesses never reach either downstream port.

Top module: `ls_router`

## Requirements
- R1: A word access (`req_byte`=0) with `req_addr[1:0]` not equal to 0 faults. A read responds with `rsp_err`=1 and `rsp_code`=4, a write with `rsp_err`=1 and `rsp_code`=5. No downstream request is issued.
- R2: The alignment test takes priority over the device window. A misaligned word access inside the window faults as in R1 and issues no device request.
- R3: An access that is not refused by R1 and whose address lies in [DEV_BASE, DEV_TOP], both ends inclusive, is issued on the device port with the address unchanged. This includes byte accesses, which get no lane inversion.
- R4: Any other access goes to RAM with offset equal to the address. If that offset is greater than or equal to RAM_SIZE, the access faults with code 4 (read) or 5 (write) and no request is issued.
- R5: Byte accesses are never refused for alignment. They follow R3 and R4.
- R6: With BIG_ENDIAN=1 (the default), a byte access to RAM uses the address with bits [1:0] XORed with 2'b11, both for the bound test and on `ram_req_addr`. With BIG_ENDIAN=0 the address is unchanged.
- R7: A byte read returns `{24'b0, downstream_rdata[7:0]}`. A byte write presents `{24'b0, req_wdata[7:0]}` downstream. Word data passes through unchanged. Writes and faults respond with `rsp_rdata`=0.
- R8: Every accepted request (`req_valid`&&`req_ready`) yields exactly one single-cycle `rsp_valid` pulse. A success has `rsp_err`=0 and `rsp_code`=0. `req_ready` is low from acceptance until that response has been given.
- R9: A fault responds in the cycle after acceptance. A routed access raises a one-cycle downstream request in the cycle after acceptance. Its response is given in the cycle after the downstream `*_rsp_valid` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Router idle, request accepted this cycle |
| req_addr | input | 32 | Physical address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_wdata | input | 32 | Store data (byte in bits [7:0]) |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is a fault |
| rsp_code | output | 4 | 0 ok, 4 load fault, 5 store fault |
| rsp_rdata | output | 32 | Read data |
| dev_req_valid | output | 1 | One-cycle device request |
| dev_req_write | output | 1 | Device request direction |
| dev_req_byte | output | 1 | Device request size |
| dev_req_addr | output | 32 | Device address |
| dev_req_wdata | output | 32 | Device store data |
| dev_rsp_valid | input | 1 | Device completion |
| dev_rsp_rdata | input | 32 | Device read data |
| ram_req_valid | output | 1 | One-cycle RAM request |
| ram_req_write | output | 1 | RAM request direction |
| ram_req_byte | output | 1 | RAM request size |
| ram_req_addr | output | 32 | RAM byte offset |
| ram_req_wdata | output | 32 | RAM store data |
| ram_rsp_valid | input | 1 | RAM completion |
| ram_rsp_rdata | input | 32 | RAM read data |

## Verification
A request is presented at a falling edge and accepted at the next rising edge. At the falling edge after that, either the fault response or the single downstream request must already be visible, and `req_ready` must be low. The bench's downstream model answers one cycle later. The router's response must then appear exactly one falling edge after the model's completion pulse. The driver, the downstream model and the response monitor each sample at those falling edges, so every result is compared in the exact cycle the requirements put it in.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 4;

    localparam logic [CW-1:0] CODE_OK        = 4'd0;
    localparam logic [CW-1:0] CODE_LOAD_ERR  = 4'd4;
    localparam logic [CW-1:0] CODE_STORE_ERR = 4'd5;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_DEV  = 2'd1,
        DST_RAM  = 2'd2
    } dest_e;

    typedef struct packed {
        dest_e           dest;
        logic [CW-1:0]   code;
        logic [AW-1:0]   addr;
    } route_s;

    function automatic logic [CW-1:0] fault_code(input logic is_write);
        return is_write ? CODE_STORE_ERR : CODE_LOAD_ERR;
    endfunction

    function automatic logic [DW-1:0] narrow_byte(input logic [DW-1:0] d);
        return {{(DW-8){1'b0}}, d[7:0]};
    endfunction

endpackage

// File: rtl/lsr_route.sv
module lsr_route
    import lsr_pkg::*;
#(
    parameter logic [AW-1:0] DEV_BASE   = 32'h1F00_0000,
    parameter logic [AW-1:0] DEV_TOP    = 32'h1F00_FFFF,
    parameter logic [AW-1:0] RAM_SIZE   = 32'h0001_0000,
    parameter bit            BIG_ENDIAN = 1'b1
) (
    input  logic [AW-1:0] addr,
    input  logic          is_write,
    input  logic          is_byte,
    output route_s        route
);

    logic [1:0]    lane_flip;
    logic          misaligned;
    logic          in_window;
    logic [AW-1:0] ram_off;

    // Endian variant chosen at elaboration
    generate
        if (BIG_ENDIAN) begin : g_big
            assign lane_flip = 2'b11;
        end else begin : g_little
            assign lane_flip = 2'b00;
        end
    endgenerate

    assign misaligned = !is_byte && (addr[1:0] != 2'b00);
    assign in_window  = (addr >= DEV_BASE) && (addr <= DEV_TOP);
    assign ram_off    = is_byte ? {addr[AW-1:2], addr[1:0] ^ lane_flip} : addr;

    // Fixed priority: alignment, device window, RAM bound
    always_comb begin
        route.dest = DST_NONE;
        route.code = fault_code(is_write);
        route.addr = addr;
        if (misaligned) begin
            route.dest = DST_NONE;
        end else if (in_window) begin
            route.dest = DST_DEV;
            route.code = CODE_OK;
        end else if (ram_off >= RAM_SIZE) begin
            route.dest = DST_NONE;
        end else begin
            route.dest = DST_RAM;
            route.code = CODE_OK;
            route.addr = ram_off;
        end
    end

endmodule

// File: rtl/lsr_seq.sv
module lsr_seq
    import lsr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  route_s        route_in,
    input  logic          write_in,
    input  logic          byte_in,
    input  logic [DW-1:0] wdata_in,
    input  logic          dn_done,
    input  logic [DW-1:0] dn_rdata,
    output logic          idle,
    output logic          issue,
    output logic          waiting,
    output logic          respond,
    output route_s        route_q,
    output logic          write_q,
    output logic          byte_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } state_e;

    state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            route_q <= '0;
            write_q <= 1'b0;
            byte_q  <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (fire) begin
                        route_q <= route_in;
                        write_q <= write_in;
                        byte_q  <= byte_in;
                        wdata_q <= byte_in ? narrow_byte(wdata_in) : wdata_in;
                        rdata_q <= '0;
                        state   <= (route_in.dest == DST_NONE) ? ST_RESP : ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (dn_done) begin
                        if (!write_q) begin
                            rdata_q <= byte_q ? narrow_byte(dn_rdata) : dn_rdata;
                        end
                        state <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle    = (state == ST_IDLE);
    assign issue   = (state == ST_ISSUE);
    assign waiting = (state == ST_WAIT);
    assign respond = (state == ST_RESP);

endmodule

// File: rtl/ls_router.sv
module ls_router
    import lsr_pkg::*;
#(
    parameter logic [AW-1:0] DEV_BASE   = 32'h1F00_0000,
    parameter logic [AW-1:0] DEV_TOP    = 32'h1F00_FFFF,
    parameter logic [AW-1:0] RAM_SIZE   = 32'h0001_0000,
    parameter bit            BIG_ENDIAN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [31:0]   req_addr,
    input  logic          req_write,
    input  logic          req_byte,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [3:0]    rsp_code,
    output logic [31:0]   rsp_rdata,
    output logic          dev_req_valid,
    output logic          dev_req_write,
    output logic          dev_req_byte,
    output logic [31:0]   dev_req_addr,
    output logic [31:0]   dev_req_wdata,
    input  logic          dev_rsp_valid,
    input  logic [31:0]   dev_rsp_rdata,
    output logic          ram_req_valid,
    output logic          ram_req_write,
    output logic          ram_req_byte,
    output logic [31:0]   ram_req_addr,
    output logic [31:0]   ram_req_wdata,
    input  logic          ram_rsp_valid,
    input  logic [31:0]   ram_rsp_rdata
);

    route_s        route_now;
    route_s        route_q;
    logic          idle, issue, waiting, respond;
    logic          write_q, byte_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          to_dev, to_ram;
    logic          dn_done;
    logic [DW-1:0] dn_rdata;

    lsr_route #(
        .DEV_BASE  (DEV_BASE),
        .DEV_TOP   (DEV_TOP),
        .RAM_SIZE  (RAM_SIZE),
        .BIG_ENDIAN(BIG_ENDIAN)
    ) u_route (
        .addr    (req_addr),
        .is_write(req_write),
        .is_byte (req_byte),
        .route   (route_now)
    );

    assign to_dev   = (route_q.dest == DST_DEV);
    assign to_ram   = (route_q.dest == DST_RAM);
    assign dn_done  = waiting && ((to_dev && dev_rsp_valid) || (to_ram && ram_rsp_valid));
    assign dn_rdata = to_dev ? dev_rsp_rdata : ram_rsp_rdata;

    lsr_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .fire    (req_valid && idle),
        .route_in(route_now),
        .write_in(req_write),
        .byte_in (req_byte),
        .wdata_in(req_wdata),
        .dn_done (dn_done),
        .dn_rdata(dn_rdata),
        .idle    (idle),
        .issue   (issue),
        .waiting (waiting),
        .respond (respond),
        .route_q (route_q),
        .write_q (write_q),
        .byte_q  (byte_q),
        .wdata_q (wdata_q),
        .rdata_q (rdata_q)
    );

    assign req_ready = idle;

    assign rsp_valid = respond;
    assign rsp_err   = (route_q.code != CODE_OK);
    assign rsp_code  = route_q.code;
    assign rsp_rdata = rdata_q;

    assign dev_req_valid = issue && to_dev;
    assign dev_req_write = write_q;
    assign dev_req_byte  = byte_q;
    assign dev_req_addr  = route_q.addr;
    assign dev_req_wdata = wdata_q;

    assign ram_req_valid = issue && to_ram;
    assign ram_req_write = write_q;
    assign ram_req_byte  = byte_q;
    assign ram_req_addr  = route_q.addr;
    assign ram_req_wdata = wdata_q;

endmodule

// File: rtl/lsr_checker.sv
module lsr_checker #(
    parameter logic [31:0] DEV_BASE = 32'h1F00_0000,
    parameter logic [31:0] DEV_TOP  = 32'h1F00_FFFF,
    parameter logic [31:0] RAM_SIZE = 32'h0001_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [3:0]  rsp_code,
    input logic        dev_req_valid,
    input logic        dev_req_byte,
    input logic [31:0] dev_req_addr,
    input logic        ram_req_valid,
    input logic        ram_req_byte,
    input logic [31:0] ram_req_addr,
    input logic        dev_rsp_valid,
    input logic        ram_rsp_valid
);

    assert_fault_code_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_code == 4'd4 || rsp_code == 4'd5));

    assert_word_dev_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        (dev_req_valid && !dev_req_byte) |-> (dev_req_addr[1:0] == 2'b00));

    assert_dev_in_window_R3: assert property (@(posedge clk) disable iff (rst)
        dev_req_valid |-> (dev_req_addr >= DEV_BASE && dev_req_addr <= DEV_TOP));

    assert_ram_in_bound_R4: assert property (@(posedge clk) disable iff (rst)
        ram_req_valid |-> (ram_req_addr < RAM_SIZE));

    assert_word_ram_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        (ram_req_valid && !ram_req_byte) |-> (ram_req_addr[1:0] == 2'b00));

    assert_single_target_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dev_req_valid, ram_req_valid, rsp_valid, req_ready}));

    assert_rsp_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_accept_reacts_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rsp_valid || dev_req_valid || ram_req_valid));

    assert_done_responds_R9: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !rsp_valid && !dev_req_valid && (dev_rsp_valid || ram_rsp_valid))
            |=> rsp_valid);

endmodule

bind ls_router lsr_checker #(
    .DEV_BASE(DEV_BASE),
    .DEV_TOP (DEV_TOP),
    .RAM_SIZE(RAM_SIZE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_code     (rsp_code),
    .dev_req_valid(dev_req_valid),
    .dev_req_byte (dev_req_byte),
    .dev_req_addr (dev_req_addr),
    .ram_req_valid(ram_req_valid),
    .ram_req_byte (ram_req_byte),
    .ram_req_addr (ram_req_addr),
    .dev_rsp_valid(dev_rsp_valid),
    .ram_rsp_valid(ram_rsp_valid)
);

// File: tb/ls_router_test.sv
`timescale 1ns/1ps
module ls_router_test;

    localparam logic [31:0] DBASE = 32'h1F00_0000;
    localparam logic [31:0] DTOP  = 32'h1F00_FFFF;
    localparam logic [31:0] RSIZE = 32'h0001_0000;

    typedef struct {
        logic        err;
        logic [3:0]  code;
        logic [31:0] data;
        string       tag;
    } rsp_item_t;

    typedef struct {
        logic        dev;
        logic [31:0] addr;
        logic        wr;
        logic        byt;
        logic [31:0] wdata;
        string       tag;
    } dn_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_byte = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [3:0]  rsp_code;
    logic [31:0] rsp_rdata;
    logic        dev_req_valid, dev_req_write, dev_req_byte;
    logic [31:0] dev_req_addr, dev_req_wdata;
    logic        dev_rsp_valid = 1'b0;
    logic [31:0] dev_rsp_rdata = '0;
    logic        ram_req_valid, ram_req_write, ram_req_byte;
    logic [31:0] ram_req_addr, ram_req_wdata;
    logic        ram_rsp_valid = 1'b0;
    logic [31:0] ram_rsp_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    rsp_item_t rsp_q[$];
    dn_item_t  dn_q[$];

    always #4 clk = ~clk;

    ls_router uut (.*);

    function automatic logic [31:0] model_data(input logic [31:0] a);
        return {~a[15:0], 8'hE7, a[7:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: computes the expected outcome from the requirements
    task automatic send(input logic [31:0] a, input logic w, input logic b,
                        input logic [31:0] wd, input string tag);
        rsp_item_t   r;
        dn_item_t    d;
        logic [31:0] off;
        logic        routed;
        off    = b ? {a[31:2], a[1:0] ^ 2'b11} : a;
        routed = 1'b0;
        r.tag  = tag;
        r.data = '0;
        r.err  = 1'b1;
        r.code = w ? 4'd5 : 4'd4;
        if (!b && a[1:0] != 2'b00) begin
            routed = 1'b0;
        end else if (a >= DBASE && a <= DTOP) begin
            routed = 1'b1; d.dev = 1'b1; d.addr = a;
        end else if (off < RSIZE) begin
            routed = 1'b1; d.dev = 1'b0; d.addr = off;
        end
        if (routed) begin
            r.err = 1'b0; r.code = 4'd0;
            if (!w) r.data = b ? {24'b0, model_data(d.addr)[7:0]} : model_data(d.addr);
            d.wr = w; d.byt = b; d.tag = tag;
            d.wdata = b ? {24'b0, wd[7:0]} : wd;
            dn_q.push_back(d);
        end
        rsp_q.push_back(r);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_byte = b; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8", {tag, " ready low while busy"}, 32'(req_ready), 0);
        if (routed) begin
            check(rsp_valid == 1'b0, "R9", {tag, " no early response"}, 32'(rsp_valid), 0);
        end else begin
            check(rsp_valid == 1'b1, "R9", {tag, " fault response next cycle"}, 32'(rsp_valid), 1);
            check(!dev_req_valid && !ram_req_valid, "R1", {tag, " no downstream request"},
                  {30'b0, dev_req_valid, ram_req_valid}, 0);
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    // Downstream model: checks the issued request, completes one cycle later
    initial begin
        forever begin
            @(negedge clk);
            if (dev_req_valid || ram_req_valid) begin
                dn_item_t    e;
                logic        is_dev;
                logic [31:0] a;
                is_dev = dev_req_valid;
                a = is_dev ? dev_req_addr : ram_req_addr;
                if (dn_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected downstream request", a, 0);
                end else begin
                    e = dn_q.pop_front();
                    check(is_dev == e.dev, "R3", {e.tag, " target port"}, 32'(is_dev), 32'(e.dev));
                    check(a == e.addr, "R6", {e.tag, " downstream address"}, a, e.addr);
                    check((is_dev ? dev_req_wdata : ram_req_wdata) == e.wdata, "R7",
                          {e.tag, " downstream write data"},
                          is_dev ? dev_req_wdata : ram_req_wdata, e.wdata);
                    check((is_dev ? dev_req_byte : ram_req_byte) == e.byt &&
                          (is_dev ? dev_req_write : ram_req_write) == e.wr, "R5",
                          {e.tag, " size/direction"}, 0, 0);
                end
                @(negedge clk);
                if (is_dev) begin dev_rsp_valid = 1'b1; dev_rsp_rdata = model_data(a); end
                else        begin ram_rsp_valid = 1'b1; ram_rsp_rdata = model_data(a); end
                @(negedge clk);
                dev_rsp_valid = 1'b0; ram_rsp_valid = 1'b0;
                check(rsp_valid == 1'b1, "R9", "response one cycle after completion",
                      32'(rsp_valid), 1);
            end
        end
    end

    // Monitor: pops the scoreboard on every response
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                rsp_item_t e;
                if (rsp_q.size() == 0) begin
                    check(1'b0, "R8", "response without request", 32'(rsp_code), 0);
                end else begin
                    e = rsp_q.pop_front();
                    check(rsp_err == e.err && rsp_code == e.code, "R8",
                          {e.tag, " error/code"}, {27'b0, rsp_err, rsp_code},
                          {27'b0, e.err, e.code});
                    check(rsp_rdata == e.data, "R7", {e.tag, " read data"}, rsp_rdata, e.data);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            check(1'b0, "R8", "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && !rsp_valid && !dev_req_valid && !ram_req_valid,
              "R8", "reset state", {28'b0, req_ready, rsp_valid, dev_req_valid, ram_req_valid},
              32'h8);

        send(32'h0000_0100, 1'b0, 1'b0, 32'h0,          "R4 word read RAM");
        send(32'h0000_0104, 1'b1, 1'b0, 32'hCAFE_F00D,  "R4 word write RAM");
        send(32'h0000_0102, 1'b0, 1'b0, 32'h0,          "R1 misaligned load");
        send(32'h0000_0101, 1'b1, 1'b0, 32'h1234_5678,  "R1 misaligned store");
        send(32'h1F00_0002, 1'b0, 1'b0, 32'h0,          "R2 misaligned in window");
        send(32'h1F00_0000, 1'b0, 1'b0, 32'h0,          "R3 device base");
        send(32'h1F00_FFFC, 1'b1, 1'b0, 32'h0BAD_BEEF,  "R3 device top word");
        send(32'h1F00_FFFF, 1'b0, 1'b1, 32'h0,          "R3 R5 device top byte");
        send(32'h0000_FFFC, 1'b0, 1'b0, 32'h0,          "R4 last RAM word");
        send(32'h0001_0000, 1'b0, 1'b0, 32'h0,          "R4 RAM bound load");
        send(32'h0001_0000, 1'b1, 1'b1, 32'h0000_00AA,  "R4 RAM bound byte store");
        send(32'h2000_0000, 1'b1, 1'b0, 32'h1,          "R4 far store");
        send(32'h0000_0203, 1'b0, 1'b1, 32'h0,          "R6 R7 byte read lane");
        send(32'h0000_0201, 1'b1, 1'b1, 32'hFFFF_FF5C,  "R6 R7 byte write lane");
        send(32'h0000_FFFF, 1'b0, 1'b1, 32'h0,          "R5 R6 last RAM byte");
        send(32'h1EFF_FFFF, 1'b0, 1'b1, 32'h0,          "R4 below window");
        send(32'h1F01_0000, 1'b1, 1'b1, 32'h0,          "R4 above window");

        repeat (6) @(negedge clk);
        check(rsp_q.size() == 0 && dn_q.size() == 0, "R8", "all requests answered",
              rsp_q.size() + dn_q.size(), 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule